// File: doc/BRIEF.md
# Page Single-Error-Correcting ECC Engine

This block sits beside a NAND flash data path and watches every beat of a page as it crosses an 8-bit or 16-bit bus. While the page streams past, it keeps a 16-bit Hamming-style parity and a matching inverted parity. Each value is built from the positions of the 1 bits in the page, where a position is a word address joined to a bit offset. When the page is written, software reads both values and stores the four code bytes in the spare area.

On a read, the four stored code bytes follow the last data byte in the same stream. The engine captures them and compares them with what it computed. It then reports one of four outcomes: the page is clean, one data bit is wrong (its position is given), one bit of the stored code itself is wrong, or the damage cannot be corrected. A freshly erased page (all ones, code included) shows up as a multiple-error report whose address fields are all ones, so software can tell it apart from a real failure.

Configuration and results go through a small word-addressed register port. The port has a clear control, a mode register that selects page length and bus width, a status register, and the parity and inverted-parity registers.

Top module: `page_ecc_engine`

## Requirements
- R1: After reset, or after a write of 1 to bit 0 of the control register (byte address 0x00), the status register (0x08), the parity register (0x0C) and the inverted-parity register (0x10) all read 0.
- R2: After the page data has been streamed, the parity register bits [15:0] hold the XOR of the positions of all 1 data bits, and the inverted-parity register holds the XOR of their bitwise complements. A position is {word address[11:0], bit offset[3:0]}. In 16-bit mode a beat is one word, its bits 0..15 give the offset, and the first data byte is carried on lane [7:0]. Register reads return data one clock after the read strobe.
- R3: Mode register (0x04): bits [1:0] select a page length, including the spare area, of 528 << value bytes, and bit 4 set selects the 16-bit bus. The register reads back those bits, and every other bit reads 0.
- R4: In 8-bit mode only lane [7:0] is used: each byte is one word, bit offsets run from 0 to 7, and lane [15:8] has no effect on any result.
- R5: After exactly the selected number of data bytes, the next four bytes are taken as the stored code, in this order: parity low, parity high, inverted-parity low, inverted-parity high. In 16-bit mode they arrive as two beats, parity first, with the low byte on lane [7:0].
- R6: If the stored code matches the computed code, status bits [2:0] read 000 and the parity register reads 0.
- R7: If exactly one data bit differs, status reads 001 and the parity register gives that bit's position: bits [15:4] hold the word address and bits [3:0] the bit offset.
- R8: If exactly one of the 32 stored code bits differs, status reads 011: bit 0 flags an error and bit 1 flags an error in the code itself.
- R9: Any other mismatch sets status to 101: bit 0 flags an error and bit 2 flags a multiple error.
- R10: A page whose data and stored code are all 0xFF reports status 101, with parity register bits [15:0] equal to 0xFFFF.
- R11: Once a check has completed, further stream beats change neither the status nor the parity registers until the next clear.
- R12: A clear write in the same cycle as a stream beat discards that beat, and byte counting restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after reg_rd |
| st_valid | input | 1 | Stream beat valid |
| st_data | input | 16 | Stream beat (lane [7:0] only in 8-bit mode) |

## Verification
Two functions can fall in the same cycle: the clear command arriving on the register port, and a data beat arriving on the stream. The bench drives a clear write and a nonzero beat on the same clock edge. It then reads the parity register, which must still be zero, and streams a full page, whose parity must match a page counted from address 0. Either symptom shows that the beat leaked into the accumulators or into the byte counter.

// File: rtl/pecc_pkg.sv
package pecc_pkg;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_CODE  = 2'd1,
    PH_CHECK = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // Register word indices (byte address >> 2)
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_MODE = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_PAR  = 3'd3;
  localparam logic [2:0] RA_NPAR = 3'd4;

endpackage

// File: rtl/pecc_accum.sv
module pecc_accum
  import pecc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WADDR_W    = 12,
  parameter int BOFF_W     = 4,
  parameter int BASE_BYTES = 528,
  localparam int POS_W      = WADDR_W + BOFF_W,
  localparam int CODE_W     = 2 * POS_W,
  localparam int CODE_BYTES = CODE_W / 8,
  localparam int CCNT_W     = $clog2(CODE_BYTES),
  localparam int CNT_W      = $clog2(BASE_BYTES * 8 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bus16,
  input  logic [1:0]        psize,
  input  logic              st_valid,
  input  logic [DATA_W-1:0] st_data,
  output logic [POS_W-1:0]  p_acc,
  output logic [POS_W-1:0]  n_acc,
  output logic [CODE_W-1:0] code_st,
  output logic              chk_go,
  output phase_e            phase
);

  logic [CNT_W-1:0]  byte_cnt;
  logic [CCNT_W-1:0] code_cnt;
  logic [CNT_W-1:0]  page_bytes;
  logic [CNT_W-1:0]  byte_nxt;
  logic [CNT_W-1:0]  widx;
  logic [DATA_W-1:0] dm;
  logic              odd;
  logic [BOFF_W-1:0] xb;
  logic [WADDR_W-1:0] waddr;
  logic [POS_W-1:0]  contrib;
  logic              code_last;

  always_comb begin
    page_bytes = CNT_W'(BASE_BYTES) << psize;
    byte_nxt   = byte_cnt + CNT_W'(bus16 ? 2 : 1);
    dm         = bus16 ? st_data : {{(DATA_W-8){1'b0}}, st_data[7:0]};
    odd        = ^dm;
    xb         = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (dm[i]) xb = xb ^ BOFF_W'(i);
    end
    widx      = bus16 ? (byte_cnt >> 1) : byte_cnt;
    waddr     = widx[WADDR_W-1:0];
    contrib   = {({WADDR_W{odd}} & waddr), xb};
    code_last = bus16 ? (code_cnt == CCNT_W'(CODE_BYTES/2 - 1))
                      : (code_cnt == CCNT_W'(CODE_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase    <= PH_DATA;
      byte_cnt <= '0;
      code_cnt <= '0;
      p_acc    <= '0;
      n_acc    <= '0;
      code_st  <= '0;
      chk_go   <= 1'b0;
    end else begin
      chk_go <= 1'b0;
      case (phase)
        PH_DATA: if (st_valid) begin
          p_acc    <= p_acc ^ contrib;
          n_acc    <= n_acc ^ contrib ^ {POS_W{odd}};
          byte_cnt <= byte_nxt;
          if (byte_nxt >= page_bytes) phase <= PH_CODE;
        end
        PH_CODE: if (st_valid) begin
          if (bus16) code_st[{code_cnt[CCNT_W-2:0], 4'b0000} +: 16] <= st_data[15:0];
          else       code_st[{code_cnt, 3'b000} +: 8]              <= st_data[7:0];
          code_cnt <= code_cnt + 1'b1;
          if (code_last) begin
            phase  <= PH_CHECK;
            chk_go <= 1'b1;
          end
        end
        PH_CHECK: phase <= PH_DONE;
        default:  phase <= PH_DONE;
      endcase
    end
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (p_acc == '0 && n_acc == '0 && phase == PH_DATA));

  // R11
  hold_done_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE && !clr) |=> ($stable(p_acc) && $stable(code_st)));

  // R5
  code_only_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CODE && !clr) |=> ($stable(p_acc) && $stable(n_acc)));

endmodule

// File: rtl/pecc_syndrome.sv
module pecc_syndrome #(
  parameter int POS_W = 16,
  localparam int CODE_W = 2 * POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk_go,
  input  logic [POS_W-1:0]  p_acc,
  input  logic [POS_W-1:0]  n_acc,
  input  logic [CODE_W-1:0] code_st,
  output logic              flag_any,
  output logic              flag_code,
  output logic              flag_multi,
  output logic [POS_W-1:0]  syn_p,
  output logic [POS_W-1:0]  syn_n,
  output logic              checked
);

  logic [POS_W-1:0] dp, dn;
  logic             clean, single_data, single_code;

  always_comb begin
    dp          = p_acc ^ code_st[POS_W-1:0];
    dn          = n_acc ^ code_st[CODE_W-1:POS_W];
    clean       = (dp == '0) && (dn == '0);
    single_data = (dp == ~dn);
    single_code = ($countones({dp, dn}) == 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag_any   <= 1'b0;
      flag_code  <= 1'b0;
      flag_multi <= 1'b0;
      syn_p      <= '0;
      syn_n      <= '0;
      checked    <= 1'b0;
    end else if (chk_go) begin
      checked    <= 1'b1;
      syn_p      <= dp;
      syn_n      <= dn;
      flag_any   <= !clean;
      flag_code  <= !clean && !single_data && single_code;
      flag_multi <= !clean && !single_data && !single_code;
    end
  end

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flag_code && flag_multi));

  // R9
  sub_any_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_code || flag_multi) |-> flag_any);

  // R5
  go_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(checked) |-> $past(chk_go));

endmodule

// File: rtl/page_ecc_engine.sv
module page_ecc_engine
  import pecc_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 32,
  parameter int DATA_W     = 16,
  parameter int WADDR_W    = 12,
  parameter int BOFF_W     = 4,
  parameter int BASE_BYTES = 528
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              st_valid,
  input  logic [DATA_W-1:0] st_data
);

  localparam int POS_W  = WADDR_W + BOFF_W;
  localparam int CODE_W = 2 * POS_W;

  logic              mode_bus16;
  logic [1:0]        mode_psize;
  logic              clr;
  logic [2:0]        widx;
  logic [POS_W-1:0]  p_acc, n_acc, syn_p, syn_n;
  logic [CODE_W-1:0] code_st;
  logic              chk_go, checked;
  logic              flag_any, flag_code, flag_multi;
  phase_e            phase;

  assign widx = reg_addr[ADDR_W-1:2];
  assign clr  = reg_wr && (widx == RA_CTRL) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_bus16 <= 1'b0;
      mode_psize <= 2'd0;
    end else if (reg_wr && widx == RA_MODE) begin
      mode_bus16 <= reg_wdata[4];
      mode_psize <= reg_wdata[1:0];
    end
  end

  pecc_accum #(
    .DATA_W(DATA_W), .WADDR_W(WADDR_W), .BOFF_W(BOFF_W), .BASE_BYTES(BASE_BYTES)
  ) u_accum (
    .clk(clk), .rst(rst), .clr(clr),
    .bus16(mode_bus16), .psize(mode_psize),
    .st_valid(st_valid), .st_data(st_data),
    .p_acc(p_acc), .n_acc(n_acc), .code_st(code_st),
    .chk_go(chk_go), .phase(phase)
  );

  pecc_syndrome #(.POS_W(POS_W)) u_syn (
    .clk(clk), .rst(rst), .clr(clr), .chk_go(chk_go),
    .p_acc(p_acc), .n_acc(n_acc), .code_st(code_st),
    .flag_any(flag_any), .flag_code(flag_code), .flag_multi(flag_multi),
    .syn_p(syn_p), .syn_n(syn_n), .checked(checked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (widx)
        RA_MODE: reg_rdata <= REG_W'({mode_bus16, 2'b00, mode_psize});
        RA_STAT: reg_rdata <= REG_W'({flag_multi, flag_code, flag_any});
        RA_PAR:  reg_rdata <= REG_W'(checked ? syn_p : p_acc);
        RA_NPAR: reg_rdata <= REG_W'(checked ? syn_n : n_acc);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R6
  clean_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (checked && !flag_any) |-> (syn_p == '0 && syn_n == '0));

  // R11
  checked_phase_chk: assert property (@(posedge clk) disable iff (rst)
    checked |-> (phase == PH_DONE));

endmodule

// File: tb/page_ecc_engine_bench.sv
`timescale 1ns/1ps
module page_ecc_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st_valid = 1'b0;
  logic [15:0] st_data = '0;

  always #4 clk = ~clk;

  page_ecc_engine u_page_ecc_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_valid(st_valid), .st_data(st_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  page_mem [0:4223];
  logic [31:0] rd_val;
  logic [15:0] pc, nc;

  typedef struct packed {
    logic        bus16;
    logic [1:0]  psize;
    logic [7:0]  seed;
    logic [1:0]  kind;    // 0 none, 1 data bit, 2 code bit, 3 two data bits
    logic [12:0] fb;
    logic [2:0]  fbit;
    logic [12:0] fb2;
    logic [2:0]  fbit2;
    logic [4:0]  cbit;
    logic [2:0]  exp_st;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h3B, 2'd0, 13'd0,    3'd0, 13'd0,   3'd0, 5'd0,  3'b000},
    '{1'b0, 2'd0, 8'hA5, 2'd1, 13'd300,  3'd5, 13'd0,   3'd0, 5'd0,  3'b001},
    '{1'b1, 2'd1, 8'h17, 2'd1, 13'd777,  3'd2, 13'd0,   3'd0, 5'd0,  3'b001},
    '{1'b1, 2'd0, 8'h6C, 2'd2, 13'd0,    3'd0, 13'd0,   3'd0, 5'd21, 3'b011},
    '{1'b0, 2'd1, 8'h91, 2'd3, 13'd10,   3'd1, 13'd500, 3'd7, 5'd0,  3'b101},
    '{1'b1, 2'd3, 8'h2D, 2'd1, 13'd4223, 3'd0, 13'd0,   3'd0, 5'd0,  3'b001},
    '{1'b0, 2'd2, 8'h4E, 2'd2, 13'd0,    3'd0, 13'd0,   3'd0, 5'd0,  3'b011}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; rd_val = reg_rdata;
  endtask

  function automatic void calc(input logic b16, input int nbytes,
                               output logic [15:0] p, output logic [15:0] n);
    logic [15:0] pos;
    p = '0; n = '0;
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (page_mem[i][b]) begin
          if (b16) pos = {12'(i / 2), 4'((i % 2) * 8 + b)};
          else     pos = {12'(i), 4'(b)};
          p = p ^ pos;
          n = n ^ ~pos;
        end
      end
    end
  endfunction

  task automatic send_page(input logic b16, input int nbytes,
                           input logic with_code, input logic [31:0] code);
    if (b16) begin
      for (int k = 0; k < nbytes / 2; k++) begin
        @(negedge clk); st_valid = 1'b1;
        st_data = {page_mem[2*k+1], page_mem[2*k]};
      end
      if (with_code) begin
        for (int k = 0; k < 2; k++) begin
          @(negedge clk); st_valid = 1'b1; st_data = code[16*k +: 16];
        end
      end
    end else begin
      for (int k = 0; k < nbytes; k++) begin
        @(negedge clk); st_valid = 1'b1;
        st_data = {page_mem[k] ^ 8'h5A, page_mem[k]};  // junk on upper lane (R4)
      end
      if (with_code) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk); st_valid = 1'b1; st_data = {8'hC3, code[8*k +: 8]};
        end
      end
    end
    @(negedge clk); st_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nb;
    logic [31:0] code;
    logic [15:0] epos;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state (R1)
    reg_read(5'h08); check("R1 status after reset", rd_val, 32'h0);
    reg_read(5'h0C); check("R1 parity after reset", rd_val, 32'h0);
    reg_read(5'h10); check("R1 inv parity after reset", rd_val, 32'h0);
    reg_read(5'h04); check("R3 mode after reset", rd_val, 32'h0);

    // Mode readback (R3)
    reg_write(5'h04, 32'hFFFF_FFFF);
    reg_read(5'h04); check("R3 mode readback masked", rd_val, 32'h13);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      nb = 528 << VECS[v].psize;
      reg_write(5'h04, {27'b0, VECS[v].bus16, 2'b00, VECS[v].psize});
      reg_write(5'h00, 32'h1);
      for (int i = 0; i < nb; i++)
        page_mem[i] = 8'((i * (VECS[v].seed | 8'h01) + (i >> 5)) ^ VECS[v].seed);
      calc(VECS[v].bus16, nb, pc, nc);
      send_page(VECS[v].bus16, nb, 1'b0, 32'h0);
      reg_read(5'h0C); check(VECS[v].bus16 ? "R2 parity" : "R2 R4 parity 8-bit", rd_val, {16'h0, pc});
      reg_read(5'h10); check(VECS[v].bus16 ? "R2 inv parity" : "R2 R4 inv parity 8-bit", rd_val, {16'h0, nc});

      reg_write(5'h00, 32'h1);
      code = {nc, pc};
      if (VECS[v].kind == 2'd1 || VECS[v].kind == 2'd3)
        page_mem[VECS[v].fb][VECS[v].fbit] = ~page_mem[VECS[v].fb][VECS[v].fbit];
      if (VECS[v].kind == 2'd3)
        page_mem[VECS[v].fb2][VECS[v].fbit2] = ~page_mem[VECS[v].fb2][VECS[v].fbit2];
      if (VECS[v].kind == 2'd2) code[VECS[v].cbit] = ~code[VECS[v].cbit];
      send_page(VECS[v].bus16, nb, 1'b1, code);
      reg_read(5'h08);
      case (VECS[v].kind)
        2'd0: check("R5 R6 status clean", rd_val, {29'b0, VECS[v].exp_st});
        2'd1: check("R7 status data bit", rd_val, {29'b0, VECS[v].exp_st});
        2'd2: check("R8 status code bit", rd_val, {29'b0, VECS[v].exp_st});
        default: check("R9 status multiple", rd_val, {29'b0, VECS[v].exp_st});
      endcase
      if (VECS[v].kind == 2'd0) begin
        reg_read(5'h0C); check("R6 parity clean", rd_val, 32'h0);
      end
      if (VECS[v].kind == 2'd1) begin
        if (VECS[v].bus16)
          epos = {12'(VECS[v].fb >> 1), 4'(VECS[v].fb[0] ? 8 + VECS[v].fbit : VECS[v].fbit)};
        else
          epos = {VECS[v].fb[11:0], 1'b0, VECS[v].fbit};
        reg_read(5'h0C); check("R7 error position", rd_val, {16'h0, epos});
      end
    end

    // Erased page (R10)
    reg_write(5'h04, 32'h0);
    reg_write(5'h00, 32'h1);
    for (int i = 0; i < 528; i++) page_mem[i] = 8'hFF;
    send_page(1'b0, 528, 1'b1, 32'hFFFF_FFFF);
    reg_read(5'h08); check("R10 erased status", rd_val, 32'h5);
    reg_read(5'h0C); check("R10 erased address fields", rd_val, 32'h0000_FFFF);

    // Beats after completion ignored (R11)
    for (int i = 0; i < 20; i++) page_mem[i] = 8'h01;
    send_page(1'b0, 20, 1'b0, 32'h0);
    reg_read(5'h08); check("R11 status held", rd_val, 32'h5);
    reg_read(5'h0C); check("R11 parity held", rd_val, 32'h0000_FFFF);

    // Clear and beat in the same cycle (R12)
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h1;
    st_valid = 1'b1; st_data = 16'h00F3;
    @(negedge clk);
    reg_wr = 1'b0; st_valid = 1'b0;
    reg_read(5'h0C); check("R12 beat discarded", rd_val, 32'h0);
    for (int i = 0; i < 528; i++) page_mem[i] = 8'(i * 13 + 7);
    calc(1'b0, 528, pc, nc);
    send_page(1'b0, 528, 1'b0, 32'h0);
    reg_read(5'h0C); check("R12 counting restarts", rd_val, {16'h0, pc});

    // Clear after data (R1)
    reg_write(5'h00, 32'h1);
    reg_read(5'h0C); check("R1 parity cleared", rd_val, 32'h0);
    reg_read(5'h10); check("R1 inv parity cleared", rd_val, 32'h0);
    reg_read(5'h08); check("R1 status cleared", rd_val, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule